// File: doc/BRIEF.md
# Page-Walk Store-Ordering Checker

This block sits beside a hardware page-table walker and decides whether the entries a walk has read may be used, given the stores that are older than the walk and have not yet committed. It watches a snapshot of the store queue. Each slot carries a valid bit, an address-known bit, a byte address and an age tag. It also watches the stream of entry-read addresses the walker issues. Only stores with an age tag strictly smaller than the walk's own tag count as older. Younger stores and empty slots play no part.

Three checking policies are available per walk. With checking off, reads flow freely and every walk is committed. The hold policy back-pressures the walker's read stream until no older store is left in the queue, so a conflict cannot arise. The speculative policy lets reads go at once. It compares every accepted read against every older store at 4-byte granularity, and it treats any older store whose address is still unresolved as a conflict. A walk that has run more than a set number of cycles while an older store is still unresolved is also flagged, even if no read has touched that store. Once flagged, a walk stays flagged until the next walk starts. At the end of the walk the block emits a one-cycle retry pulse and the walker discards its result. If the walk was not flagged, the block emits a one-cycle commit pulse instead.

The read stream is valid/ready. The walker holds `rd_valid` and `rd_addr` steady until a cycle in which `rd_ready` is high, and a read is taken in exactly that cycle. `rd_ready` is low whenever no walk is open, and under the hold policy it is also low while an older store is present. A walk opens on `walk_start` when no walk is open (a start while a walk is open is ignored). The mode and age tag are captured at that point, and the walk closes on `walk_end`.

Top module: `pagewalk_coherence_chk`

## Requirements
- R1: After reset, `rd_ready`, `walk_stall`, `walk_viol`, `walk_retry` and `walk_commit` are low and `viol_count` is zero.
- R2: The `chk_mode` encoding is captured at walk start: 2'b00 is off, 2'b01 is hold, and 2'b10 or 2'b11 is speculative.
- R3: In speculative mode, an accepted read whose address matches a valid, address-known, older store sets `walk_viol` on the next cycle.
- R4: In speculative mode, an accepted read while any valid older store has its address unknown (`sq_addr_known` low) sets `walk_viol`, whatever its address.
- R5: Slots with `sq_valid` low, and slots whose `sq_age` is equal to or greater than the walk's age, never cause a violation or a stall.
- R6: Addresses match when they agree in all bits above bit 1. Addresses that differ only in bits 1:0 match, and a difference in bit 2 or above does not.
- R7: In hold mode, `walk_stall` is high and `rd_ready` is low while any valid older store exists. `rd_ready` rises in the same cycle the last older store leaves.
- R8: In speculative mode, with no read at all, an older store that is still unresolved sets `walk_viol` once the walk has been open more than `LEAD_LIMIT` cycles (default 9), and not before.
- R9: The cycle after a `walk_end`, exactly one of `walk_retry` (flagged walk) or `walk_commit` (clean walk) is high, for one cycle only.
- R10: `walk_viol` stays high once set, even after the offending store resolves or leaves, until the next accepted `walk_start`. The flagged walk still ends in a retry.
- R11: `viol_count` rises by one in the same cycle as each `walk_retry` pulse and is otherwise unchanged.
- R12: In off mode, no walk is stalled or flagged, even when a matching older store is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_mode | input | 2 | Checking policy, sampled at walk start |
| walk_start | input | 1 | Opens a walk when none is open |
| walk_age | input | AGE_W | Age tag of the walk, sampled at start |
| walk_end | input | 1 | Closes the open walk |
| rd_valid | input | 1 | Entry-read address offered |
| rd_ready | output | 1 | Entry read accepted this cycle when high with rd_valid |
| rd_addr | input | ADDR_W | Byte address of the entry read |
| sq_valid | input | SQ_N | Store slot occupied |
| sq_addr_known | input | SQ_N | Store slot address resolved |
| sq_addr | input | SQ_N*ADDR_W | Store addresses, slot k at bits k*ADDR_W upward |
| sq_age | input | SQ_N*AGE_W | Store age tags, slot k at bits k*AGE_W upward |
| walk_stall | output | 1 | Hold policy is waiting on older stores |
| walk_viol | output | 1 | Sticky violation flag of the current walk |
| walk_retry | output | 1 | One-cycle pulse: discard and retry the walk |
| walk_commit | output | 1 | One-cycle pulse: walk result may be used |
| viol_count | output | CNT_W | Total count of retried walks |

## Verification
The properties rely on a few conditions on the inputs. Reset is held from time zero. `walk_end` is given only while a walk is open. Age tags do not wrap around during a walk, so unsigned "smaller" means "older". The stimulus gives `walk_end` only after a start has been accepted, and it uses small age values that never wrap. It changes the store snapshot and the read stream only between clock edges, and it holds each offered read until `rd_ready` takes it.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  typedef enum logic [1:0] {
    CHK_OFF  = 2'b00,
    CHK_HOLD = 2'b01,
    CHK_SPEC = 2'b10
  } chk_mode_e;

  function automatic logic mode_is_spec(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic mode_is_hold(input logic [1:0] m);
    return m == CHK_HOLD;
  endfunction
endpackage

// File: rtl/pwc_entry_screen.sv
module pwc_entry_screen #(
  parameter int SQ_N  = 8,
  parameter int AGE_W = 5
) (
  input  logic [SQ_N-1:0]       sq_valid,
  input  logic [SQ_N-1:0]       sq_addr_known,
  input  logic [SQ_N*AGE_W-1:0] sq_age,
  input  logic [AGE_W-1:0]      ref_age,
  output logic [SQ_N-1:0]       older_mask,
  output logic [SQ_N-1:0]       older_unres_mask
);
  for (genvar k = 0; k < SQ_N; k++) begin : g_slot
    logic [AGE_W-1:0] slot_age;
    assign slot_age            = sq_age[k*AGE_W +: AGE_W];
    assign older_mask[k]       = sq_valid[k] && (slot_age < ref_age);
    assign older_unres_mask[k] = older_mask[k] && !sq_addr_known[k];
  end
endmodule

// File: rtl/pwc_addr_match.sv
module pwc_addr_match #(
  parameter int SQ_N     = 8,
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 2
) (
  input  logic [SQ_N*ADDR_W-1:0] sq_addr,
  input  logic [SQ_N-1:0]        sq_addr_known,
  input  logic [SQ_N-1:0]        older_mask,
  input  logic [ADDR_W-1:0]      probe_addr,
  output logic [SQ_N-1:0]        hit_mask
);
  localparam logic [ADDR_W-1:0] WORD_MASK = ~((ADDR_W'(1) << GRAN_LSB) - ADDR_W'(1));

  for (genvar k = 0; k < SQ_N; k++) begin : g_cmp
    logic [ADDR_W-1:0] diff;
    assign diff        = (sq_addr[k*ADDR_W +: ADDR_W] ^ probe_addr) & WORD_MASK;
    assign hit_mask[k] = older_mask[k] && sq_addr_known[k] && (diff == '0);
  end
endmodule

// File: rtl/pwc_lead_timer.sv
module pwc_lead_timer #(
  parameter int LEAD_LIMIT = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic running,
  output logic over_limit
);
  localparam int CW = $clog2(LEAD_LIMIT + 2);
  localparam logic [CW-1:0] SAT = CW'(LEAD_LIMIT + 1);

  logic [CW-1:0] lead_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                       lead_q <= '0;
    else if (restart)                 lead_q <= '0;
    else if (running && lead_q != SAT) lead_q <= lead_q + CW'(1);
  end

  assign over_limit = running && (lead_q == SAT);
endmodule

// File: rtl/pwc_walk_ctrl.sv
module pwc_walk_ctrl
  import pwc_pkg::*;
#(
  parameter int AGE_W = 5,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       chk_mode,
  input  logic             walk_start,
  input  logic [AGE_W-1:0] walk_age,
  input  logic             walk_end,
  input  logic             rd_valid,
  input  logic             any_older,
  input  logic             any_conflict,
  input  logic             any_older_unres,
  input  logic             over_limit,
  output logic             open_q,
  output logic             start_fire,
  output logic [AGE_W-1:0] age_q,
  output logic             rd_ready,
  output logic             walk_stall,
  output logic             walk_viol,
  output logic             walk_retry,
  output logic             walk_commit,
  output logic [CNT_W-1:0] viol_count
);
  logic [1:0] mode_q;
  logic       viol_q, retry_q, commit_q;
  logic [CNT_W-1:0] cnt_q;
  logic spec_on, hold_on, rd_fire, read_viol, win_viol, new_viol, end_fire, flagged;

  assign spec_on    = open_q && mode_is_spec(mode_q);
  assign hold_on    = open_q && mode_is_hold(mode_q);
  assign walk_stall = hold_on && any_older;
  assign rd_ready   = open_q && !walk_stall;
  assign rd_fire    = rd_valid && rd_ready;
  assign read_viol  = spec_on && rd_fire && any_conflict;
  assign win_viol   = spec_on && over_limit && any_older_unres;
  assign new_viol   = read_viol || win_viol;
  assign start_fire = !open_q && walk_start;
  assign end_fire   = open_q && walk_end;
  assign flagged    = viol_q || new_viol;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q   <= 1'b0;
      mode_q   <= CHK_OFF;
      age_q    <= '0;
      viol_q   <= 1'b0;
      retry_q  <= 1'b0;
      commit_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      retry_q  <= end_fire && flagged;
      commit_q <= end_fire && !flagged;
      if (end_fire && flagged) cnt_q <= cnt_q + CNT_W'(1);
      if (start_fire) begin
        open_q <= 1'b1;
        mode_q <= chk_mode;
        age_q  <= walk_age;
        viol_q <= 1'b0;
      end else begin
        if (end_fire) open_q <= 1'b0;
        if (new_viol) viol_q <= 1'b1;
      end
    end
  end

  assign walk_viol   = viol_q;
  assign walk_retry  = retry_q;
  assign walk_commit = commit_q;
  assign viol_count  = cnt_q;
endmodule

// File: rtl/pagewalk_coherence_chk.sv
module pagewalk_coherence_chk #(
  parameter int SQ_N       = 8,
  parameter int ADDR_W     = 32,
  parameter int AGE_W      = 5,
  parameter int CNT_W      = 16,
  parameter int LEAD_LIMIT = 9,
  parameter int GRAN_LSB   = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             chk_mode,
  input  logic                   walk_start,
  input  logic [AGE_W-1:0]       walk_age,
  input  logic                   walk_end,
  input  logic                   rd_valid,
  output logic                   rd_ready,
  input  logic [ADDR_W-1:0]      rd_addr,
  input  logic [SQ_N-1:0]        sq_valid,
  input  logic [SQ_N-1:0]        sq_addr_known,
  input  logic [SQ_N*ADDR_W-1:0] sq_addr,
  input  logic [SQ_N*AGE_W-1:0]  sq_age,
  output logic                   walk_stall,
  output logic                   walk_viol,
  output logic                   walk_retry,
  output logic                   walk_commit,
  output logic [CNT_W-1:0]       viol_count
);
  logic [SQ_N-1:0]  older_mask, older_unres_mask, hit_mask;
  logic [AGE_W-1:0] age_q;
  logic open_q, start_fire, over_limit;
  logic any_older, any_conflict, any_older_unres;

  pwc_entry_screen #(.SQ_N(SQ_N), .AGE_W(AGE_W)) u_screen (
    .sq_valid(sq_valid), .sq_addr_known(sq_addr_known), .sq_age(sq_age),
    .ref_age(age_q), .older_mask(older_mask), .older_unres_mask(older_unres_mask)
  );

  pwc_addr_match #(.SQ_N(SQ_N), .ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) u_match (
    .sq_addr(sq_addr), .sq_addr_known(sq_addr_known), .older_mask(older_mask),
    .probe_addr(rd_addr), .hit_mask(hit_mask)
  );

  pwc_lead_timer #(.LEAD_LIMIT(LEAD_LIMIT)) u_lead (
    .clk(clk), .rst_n(rst_n), .restart(start_fire), .running(open_q),
    .over_limit(over_limit)
  );

  assign any_older       = |older_mask;
  assign any_older_unres = |older_unres_mask;
  assign any_conflict    = (|hit_mask) || any_older_unres;

  pwc_walk_ctrl #(.AGE_W(AGE_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .chk_mode(chk_mode), .walk_start(walk_start),
    .walk_age(walk_age), .walk_end(walk_end), .rd_valid(rd_valid),
    .any_older(any_older), .any_conflict(any_conflict),
    .any_older_unres(any_older_unres), .over_limit(over_limit),
    .open_q(open_q), .start_fire(start_fire), .age_q(age_q),
    .rd_ready(rd_ready), .walk_stall(walk_stall), .walk_viol(walk_viol),
    .walk_retry(walk_retry), .walk_commit(walk_commit), .viol_count(viol_count)
  );
endmodule

// File: rtl/pwc_checker.sv
module pwc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             walk_start,
  input logic             walk_end,
  input logic             rd_ready,
  input logic             walk_stall,
  input logic             walk_viol,
  input logic             walk_retry,
  input logic             walk_commit,
  input logic [CNT_W-1:0] viol_count
);
  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(walk_retry && walk_commit)); // R9

  AST_RETRY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    walk_retry |=> !walk_retry); // R9

  AST_VERDICT_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_retry || walk_commit) |-> $past(walk_end)); // R9

  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_viol && !walk_start) |=> walk_viol); // R10

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    walk_retry |-> viol_count == $past(viol_count) + CNT_W'(1)); // R11

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !walk_retry |-> $stable(viol_count)); // R11

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    walk_stall |-> !rd_ready); // R7
endmodule

bind pagewalk_coherence_chk pwc_checker #(.CNT_W(CNT_W)) u_pwc_chk (
  .clk(clk), .rst_n(rst_n), .walk_start(walk_start), .walk_end(walk_end),
  .rd_ready(rd_ready), .walk_stall(walk_stall), .walk_viol(walk_viol),
  .walk_retry(walk_retry), .walk_commit(walk_commit), .viol_count(viol_count)
);

// File: tb/sim_pagewalk_coherence_chk.sv
`timescale 1ns/1ps
module sim_pagewalk_coherence_chk;
  localparam int SQ_N = 8, ADDR_W = 32, AGE_W = 5, CNT_W = 16, LEAD_LIMIT = 9;
  localparam int VW = 79;
  localparam int NV = 9;
  // {mode, st_valid, st_known, st_age, walk_age, st_addr, rd_addr, expect_viol}
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'd2, 1'b1, 1'b1, 5'd5,  5'd10, 32'h0000_1000, 32'h0000_1000, 1'b1}, // R3
    {2'd2, 1'b1, 1'b1, 5'd5,  5'd10, 32'h0000_1000, 32'h0000_1003, 1'b1}, // R6
    {2'd2, 1'b1, 1'b1, 5'd5,  5'd10, 32'h0000_1004, 32'h0000_1000, 1'b0}, // R6
    {2'd2, 1'b1, 1'b1, 5'd12, 5'd10, 32'h0000_1000, 32'h0000_1000, 1'b0}, // R5
    {2'd2, 1'b1, 1'b1, 5'd10, 5'd10, 32'h0000_1000, 32'h0000_1000, 1'b0}, // R5
    {2'd2, 1'b1, 1'b0, 5'd3,  5'd10, 32'h0000_9000, 32'h0000_2000, 1'b1}, // R4
    {2'd0, 1'b1, 1'b1, 5'd5,  5'd10, 32'h0000_1000, 32'h0000_1000, 1'b0}, // R12
    {2'd3, 1'b1, 1'b1, 5'd5,  5'd10, 32'h0000_3008, 32'h0000_300A, 1'b1}, // R2
    {2'd2, 1'b0, 1'b1, 5'd5,  5'd10, 32'h0000_1000, 32'h0000_1000, 1'b0}  // R5
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] chk_mode = '0;
  logic walk_start = 1'b0, walk_end = 1'b0, rd_valid = 1'b0;
  logic [AGE_W-1:0] walk_age = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [SQ_N-1:0] sq_valid = '0, sq_addr_known = '0;
  logic [SQ_N*ADDR_W-1:0] sq_addr = '0;
  logic [SQ_N*AGE_W-1:0] sq_age = '0;
  logic rd_ready, walk_stall, walk_viol, walk_retry, walk_commit;
  logic [CNT_W-1:0] viol_count;

  int n_chk = 0, n_bad = 0;
  int exp_cnt = 0;

  always #2 clk = ~clk;

  pagewalk_coherence_chk #(.SQ_N(SQ_N), .ADDR_W(ADDR_W), .AGE_W(AGE_W), .CNT_W(CNT_W),
    .LEAD_LIMIT(LEAD_LIMIT)) u0 (
    .clk(clk), .rst_n(rst_n), .chk_mode(chk_mode), .walk_start(walk_start),
    .walk_age(walk_age), .walk_end(walk_end), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .sq_valid(sq_valid), .sq_addr_known(sq_addr_known),
    .sq_addr(sq_addr), .sq_age(sq_age), .walk_stall(walk_stall), .walk_viol(walk_viol),
    .walk_retry(walk_retry), .walk_commit(walk_commit), .viol_count(viol_count)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_slot(input int k, input logic v, input logic kn,
                          input logic [AGE_W-1:0] a, input logic [ADDR_W-1:0] ad);
    sq_valid = '0; sq_addr_known = '0; sq_addr = '0; sq_age = '0;
    sq_valid[k] = v; sq_addr_known[k] = kn;
    sq_age[k*AGE_W +: AGE_W] = a;
    sq_addr[k*ADDR_W +: ADDR_W] = ad;
  endtask

  task automatic open_walk(input logic [1:0] m, input logic [AGE_W-1:0] a);
    chk_mode = m; walk_age = a; walk_start = 1'b1;
    tick();
    walk_start = 1'b0;
  endtask

  task automatic close_walk(input string req, input logic exp_v);
    walk_end = 1'b1;
    tick();
    walk_end = 1'b0;
    if (exp_v) exp_cnt++;
    check({req, " retry"}, walk_retry, exp_v);
    check({req, " commit"}, walk_commit, !exp_v);
    check({req, " count"}, viol_count, exp_cnt);
    tick();
    check("R9 pulse width", {walk_retry, walk_commit}, 2'b00);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(); tick();
    // R1 reset state
    check("R1 outputs", {rd_ready, walk_stall, walk_viol, walk_retry, walk_commit}, 5'b0);
    check("R1 count", viol_count, 0);
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < NV; i++) begin
      logic [1:0] m; logic sv, sk, ev; logic [AGE_W-1:0] sa, wa;
      logic [ADDR_W-1:0] saddr, raddr;
      {m, sv, sk, sa, wa, saddr, raddr, ev} = VEC[i];
      set_slot(i % SQ_N, sv, sk, sa, saddr);
      open_walk(m, wa);
      check($sformatf("R2 vec%0d ready", i), rd_ready, 1'b1);
      rd_valid = 1'b1; rd_addr = raddr;
      tick();
      rd_valid = 1'b0;
      check($sformatf("R3 R4 R5 R6 vec%0d viol", i), walk_viol, ev);
      close_walk($sformatf("R9 vec%0d", i), ev);
    end

    // R7 hold mode back-pressure
    set_slot(2, 1'b1, 1'b1, 5'd4, 32'h0000_5000);
    open_walk(2'd1, 5'd9);
    rd_valid = 1'b1; rd_addr = 32'h0000_5000;
    for (int j = 0; j < 3; j++) begin
      check("R7 stall", {walk_stall, rd_ready}, 2'b10);
      tick();
    end
    sq_valid = '0; #1;
    check("R7 release", {walk_stall, rd_ready}, 2'b01);
    tick();
    rd_valid = 1'b0;
    check("R7 no flag", walk_viol, 1'b0);
    close_walk("R7", 1'b0);

    // R8 lead window with no reads
    set_slot(5, 1'b1, 1'b0, 5'd1, 32'h0000_7000);
    open_walk(2'd2, 5'd6);
    for (int j = 0; j < LEAD_LIMIT + 1; j++) tick();
    check("R8 before limit", walk_viol, 1'b0);
    tick();
    check("R8 after limit", walk_viol, 1'b1);
    // R10 store resolves, then leaves: flag stays
    sq_addr_known[5] = 1'b1;
    tick();
    check("R10 resolved", walk_viol, 1'b1);
    sq_valid = '0;
    tick(); tick();
    check("R10 gone", walk_viol, 1'b1);
    close_walk("R10", 1'b1);

    // R8 window not reached: resolve before limit
    set_slot(0, 1'b1, 1'b0, 5'd1, 32'h0000_7000);
    open_walk(2'd2, 5'd6);
    for (int j = 0; j < LEAD_LIMIT - 1; j++) tick();
    sq_addr_known[0] = 1'b1;
    tick(); tick(); tick();
    check("R8 resolved early", walk_viol, 1'b0);
    close_walk("R8", 1'b0);

    // R12 off mode with unresolved store and long walk
    set_slot(1, 1'b1, 1'b0, 5'd1, 32'h0);
    open_walk(2'd0, 5'd6);
    rd_valid = 1'b1; rd_addr = 32'h0;
    tick();
    rd_valid = 1'b0;
    for (int j = 0; j < LEAD_LIMIT + 3; j++) tick();
    check("R12 off", {walk_viol, walk_stall}, 2'b00);
    close_walk("R12", 1'b0);

    // R10 new walk clears flag after a flagged one
    set_slot(3, 1'b1, 1'b1, 5'd2, 32'h0000_0040);
    open_walk(2'd2, 5'd8);
    rd_valid = 1'b1; rd_addr = 32'h0000_0040;
    tick();
    rd_valid = 1'b0;
    check("R3 hit", walk_viol, 1'b1);
    close_walk("R11", 1'b1);
    sq_valid = '0;
    open_walk(2'd2, 5'd8);
    check("R10 cleared by start", walk_viol, 1'b0);
    close_walk("R10 clean", 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule